// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Queue

This block turns an asynchronous serial line into characters. A 16-bit divisor sets a tick rate of sixteen ticks per bit. The line passes through a two-flop synchronizer. The receiver waits for a falling edge and checks the start bit at its middle. It then samples every later bit once, at its centre.

The character length is programmable from 5 to 8 bits. The parity bit is optional and can be odd, even or a fixed value. The receiver checks the first stop bit. Each finished character goes into a 16-deep queue together with its parity-error, framing-error and break flags. The consumer sees the oldest entry on the output port while data-ready is high, and pulses a read strobe to remove it.

The frame format comes from the same line settings that drive the matching transmitter. It is held steady while a frame is in flight.

Top module: `serial_rx_top`

## Requirements
- R1: One tick is produced every `divisor` clock cycles, and a divisor of 0 acts as 1. A bit lasts 16 ticks, and frames sent at that bit period are received correctly for divisors 0, 1, 2 and 3.
- R2: After reset, `data_ready` and `overrun` are both 0.
- R3: A start is taken only on a high-to-low change of the line. If the line is high again 8 ticks after that change, no character is produced.
- R4: `char_len` selects the data width as 5 + `char_len` (0=5 … 3=8). Bits arrive least significant first. In `rd_data`, bit i holds the i-th data bit, and bits at or above the width are 0.
- R5: With `parity_on`=1 and `stick_parity`=0, the expected parity bit makes the number of ones in data plus parity even when `parity_even`=1, and odd when `parity_even`=0. A mismatch sets `rd_perr`.
- R6: With `parity_on`=1 and `stick_parity`=1, the expected parity bit is fixed. It is 0 when `parity_even`=1 and 1 when `parity_even`=0. `rd_perr` flags any other value.
- R7: A low level at the centre of the first stop bit sets `rd_ferr` for that character.
- R8: `rd_brk` is set when the start bit, all data bits, the parity bit (when enabled) and the stop bit were all sampled low. A break character also has `rd_ferr` set.
- R9: The queue holds 16 characters in arrival order. `data_ready` is high while it is non-empty. The oldest entry is shown on the `rd_*` outputs, and a one-cycle `rd_en` removes it. `rd_en` on an empty queue has no effect.
- R10: A character that completes while 16 are queued is discarded, and `overrun` is set. `overrun` stays set until reset.
- R11: With `parity_on`=0, no parity bit is expected, the stop bit directly follows the data, and `rd_perr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Clock cycles per tick, 0 treated as 1 |
| char_len | input | 2 | Data width code, width = 5 + code |
| parity_on | input | 1 | Parity bit present |
| parity_even | input | 1 | Even parity select (fixed value 0 in stick mode) |
| stick_parity | input | 1 | Parity bit fixed instead of computed |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Remove the oldest queued character |
| rd_data | output | 8 | Oldest character, zero-extended |
| rd_perr | output | 1 | Parity error flag of the oldest character |
| rd_ferr | output | 1 | Framing error flag of the oldest character |
| rd_brk | output | 1 | Break flag of the oldest character |
| data_ready | output | 1 | Queue non-empty |
| overrun | output | 1 | Sticky: a character was discarded on a full queue |

## Verification
If the tick counter or the mid-bit phase is wrong, the bits drift. Within one frame, a character appears with shifted data or a wrong framing flag. If a bit index or width decode is wrong, the damage shows in the high data bits or the parity flag of that same character. Queue pointer faults are caught by filling the queue to capacity and reading it back. The bench then sees a wrong order, a missing `overrun`, or `data_ready` out of step with the count at the sixteenth and seventeenth characters.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  // number of data bits for a width code
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // parity value the line should carry; unused data bits are zero
  function automatic logic parity_expected(input logic [7:0] d,
                                           input logic even,
                                           input logic stick);
    if (stick) return ~even;
    return even ? ^d : ~(^d);
  endfunction

endpackage

// File: rtl/rxq_baud.sv
module rxq_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (cnt == '0) cnt <= (divisor == '0) ? '0 : divisor - 1'b1;
    else                cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

  // R1: divisors above one never give back-to-back ticks
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > 1) |=> !tick);

endmodule

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rxq_frame.sv
module rxq_frame
  import rxq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxs,
  input  logic [1:0] char_len,
  input  logic       parity_on,
  input  logic       parity_even,
  input  logic       stick_parity,
  output logic       char_valid,
  output rx_char_t   char_out
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t           state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;
  logic          pbit;
  logic          armed;

  // named internal events
  logic start_seen, start_ok, start_bad, samp_evt, last_data;
  logic brk_now, perr_now;

  assign start_seen = tick && state == S_IDLE && !rxs && armed;
  assign start_ok   = tick && state == S_START && cnt == MID && !rxs;
  assign start_bad  = tick && state == S_START && cnt == MID && rxs;
  assign samp_evt   = tick && (state == S_DATA || state == S_PAR || state == S_STOP)
                      && cnt == LAST;
  assign last_data  = ({1'b0, bit_idx} == data_bits(char_len) - 4'd1);
  assign brk_now    = (shreg == '0) && (!parity_on || !pbit) && !rxs;
  assign perr_now   = parity_on && (pbit != parity_expected(shreg, parity_even, stick_parity));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      armed      <= 1'b0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (rxs) armed <= 1'b1;
      if (start_seen) begin
        state <= S_START;
        cnt   <= '0;
        armed <= 1'b0;
      end else if (start_bad) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (start_ok) begin
        state   <= S_DATA;
        cnt     <= '0;
        bit_idx <= '0;
        shreg   <= '0;
        pbit    <= 1'b0;
      end else if (samp_evt) begin
        cnt <= '0;
        unique case (state)
          S_DATA: begin
            shreg[bit_idx] <= rxs;
            if (last_data) state <= parity_on ? S_PAR : S_STOP;
            else           bit_idx <= bit_idx + 3'd1;
          end
          S_PAR: begin
            pbit  <= rxs;
            state <= S_STOP;
          end
          default: begin
            char_valid    <= 1'b1;
            char_out.data <= shreg;
            char_out.perr <= perr_now;
            char_out.ferr <= ~rxs;
            char_out.brk  <= brk_now;
            state         <= S_IDLE;
            armed         <= rxs;
          end
        endcase
      end else if (tick && state != S_IDLE) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: a break character always carries a framing error
  assert_brk_has_ferr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (!char_out.brk || char_out.ferr));
  // R4: bits at or above the selected width are zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> ((char_out.data >> data_bits(char_len)) == 8'd0));
  // R11: no parity error can be reported with parity off
  assert_no_perr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !parity_on) |-> !char_out.perr);
  // R3: a rejected start leaves the receiver idle with no character
  assert_glitch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (state == S_IDLE && !char_valid));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             full, push_ok, pop_ok, drop_evt;

  assign full     = (count == (AW+1)'(DEPTH));
  assign push_ok  = push && !full;
  assign drop_evt = push && full;
  assign pop_ok   = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (push_ok ? 1'b1 : 1'b0) - (pop_ok ? 1'b1 : 1'b0);
      if (drop_evt) overrun <= 1'b1;
    end
  end

  assign head      = mem[rd_ptr];
  assign not_empty = (count != '0);

  // R9: occupancy never exceeds the depth
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  // R9: a read of an empty queue changes nothing
  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty && !push) |=> (count == '0));
  // R10: a discarded character raises overrun
  assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun);
  // R10: overrun is sticky
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import rxq_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int OSR    = 16,
  parameter int DEPTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             parity_on,
  input  logic             parity_even,
  input  logic             stick_parity,
  input  logic             rx_in,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_perr,
  output logic             rd_ferr,
  output logic             rd_brk,
  output logic             data_ready,
  output logic             overrun
);
  localparam int EW = $bits(rx_char_t);

  logic     tick, rxs, char_valid;
  rx_char_t char_in, char_head;

  rxq_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick));

  rxq_sync #(.STAGES(STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rxs));

  rxq_frame #(.OSR(OSR)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs),
    .char_len(char_len), .parity_on(parity_on), .parity_even(parity_even),
    .stick_parity(stick_parity), .char_valid(char_valid), .char_out(char_in));

  rxq_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(char_valid), .wdata(char_in),
    .pop(rd_en), .head(char_head), .not_empty(data_ready), .overrun(overrun));

  assign rd_data = char_head.data;
  assign rd_perr = char_head.perr;
  assign rd_ferr = char_head.ferr;
  assign rd_brk  = char_head.brk;

  // R2: nothing is queued or flagged in the first cycle out of reset
  assert_reset_clean_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> (!data_ready && !overrun));

endmodule

// File: tb/serial_rx_top_tb_top.sv
module serial_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  char_len = 2'd3;
  logic        parity_on = 1'b0, parity_even = 1'b0, stick_parity = 1'b0;
  logic        rx_in = 1'b1, rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_perr, rd_ferr, rd_brk, data_ready, overrun;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .char_len(char_len),
    .parity_on(parity_on), .parity_even(parity_even), .stick_parity(stick_parity),
    .rx_in(rx_in), .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .data_ready(data_ready), .overrun(overrun));

  function automatic int bit_cycles();
    return 16 * ((divisor == 0) ? 1 : int'(divisor));
  endfunction

  function automatic logic ref_parity(input logic [7:0] d, input int n,
                                      input logic even, input logic stick);
    logic p = 1'b0;
    if (stick) return !even;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    return even ? p : !p;
  endfunction

  task automatic line_bit(input logic v);
    rx_in = v;
    repeat (bit_cycles()) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n,
                            input logic pval, input logic stopv);
    char_len = 2'(n - 5);
    line_bit(1'b0);
    for (int i = 0; i < n; i++) line_bit(d[i]);
    if (parity_on) line_bit(pval);
    line_bit(stopv);
    line_bit(1'b1);
  endtask

  task automatic check(input string req, input logic ok, input string act,
                       input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d,
                             input logic pe, input logic fe, input logic bk);
    check(req, data_ready && rd_data == d && rd_perr == pe && rd_ferr == fe && rd_brk == bk,
          $sformatf("rdy=%0b d=%02h p=%0b f=%0b b=%0b", data_ready, rd_data, rd_perr, rd_ferr, rd_brk),
          $sformatf("rdy=1 d=%02h p=%0b f=%0b b=%0b", d, pe, fe, bk));
    pop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", !data_ready && !overrun,
          $sformatf("rdy=%0b ovr=%0b", data_ready, overrun), "rdy=0 ovr=0");

    // R4 and R11: widths 5..8, no parity
    divisor = 16'd1;
    parity_on = 1'b0;
    for (int n = 5; n <= 8; n++) begin
      for (int v = 0; v < ((n == 5) ? 32 : 16); v++) begin
        logic [7:0] d, m;
        m = 8'((1 << n) - 1);
        d = (n == 5) ? 8'(v) : 8'((v * 53 + 7) & int'(m));
        send_frame(d | ~m, n, 1'b0, 1'b1);
        expect_char("R4 R11", d, 1'b0, 1'b0, 1'b0);
      end
    end

    // R5 and R6: computed and fixed parity, correct and flipped
    divisor = 16'd2;
    parity_on = 1'b1;
    for (int st = 0; st < 2; st++)
      for (int ev = 0; ev < 2; ev++)
        for (int k = 0; k < 4; k++)
          for (int flip = 0; flip < 2; flip++) begin
            logic [7:0] d;
            logic p;
            stick_parity = st[0];
            parity_even = ev[0];
            d = 8'(k * 29 + 3) & 8'h7f;
            p = ref_parity(d, 7, ev[0], st[0]) ^ flip[0];
            send_frame(d, 7, p, 1'b1);
            expect_char(st ? "R6" : "R5", d, flip[0], 1'b0, 1'b0);
          end

    // R7: stop bit low
    stick_parity = 1'b0;
    parity_even = 1'b1;
    send_frame(8'h5a, 8, ref_parity(8'h5a, 8, 1'b1, 1'b0), 1'b0);
    expect_char("R7", 8'h5a, 1'b0, 1'b1, 1'b0);

    // R8: whole frame low
    send_frame(8'h00, 8, 1'b0, 1'b0);
    expect_char("R8", 8'h00, 1'b0, 1'b1, 1'b1);
    // parity bit high is not a break
    parity_even = 1'b0;
    send_frame(8'h00, 8, 1'b1, 1'b0);
    expect_char("R8", 8'h00, 1'b0, 1'b1, 1'b0);

    // R3: short low pulse
    parity_on = 1'b0;
    divisor = 16'd1;
    rx_in = 1'b0;
    repeat (5) @(negedge clk);
    rx_in = 1'b1;
    repeat (300) @(negedge clk);
    check("R3", !data_ready, $sformatf("rdy=%0b", data_ready), "rdy=0");

    // R1: other divisors, zero acting as one
    divisor = 16'd3;
    send_frame(8'hc3, 8, 1'b0, 1'b1);
    expect_char("R1", 8'hc3, 1'b0, 1'b0, 1'b0);
    divisor = 16'd0;
    send_frame(8'h3c, 8, 1'b0, 1'b1);
    expect_char("R1", 8'h3c, 1'b0, 1'b0, 1'b0);

    // R9 and R10: fill, overflow, drain in order
    divisor = 16'd1;
    for (int i = 0; i < 16; i++) send_frame(8'(i * 13 + 1), 8, 1'b0, 1'b1);
    check("R10", !overrun && data_ready, $sformatf("ovr=%0b", overrun), "ovr=0 at 16");
    send_frame(8'hee, 8, 1'b0, 1'b1);
    check("R10", overrun, $sformatf("ovr=%0b", overrun), "ovr=1 at 17");
    for (int i = 0; i < 16; i++) expect_char("R9", 8'(i * 13 + 1), 1'b0, 1'b0, 1'b0);
    check("R9", !data_ready, $sformatf("rdy=%0b", data_ready), "rdy=0 after drain");
    pop();
    send_frame(8'h81, 8, 1'b0, 1'b1);
    check("R10", overrun, $sformatf("ovr=%0b", overrun), "ovr=1 sticky");
    expect_char("R9", 8'h81, 1'b0, 1'b0, 1'b0);
    check("R9", !data_ready, $sformatf("rdy=%0b", data_ready), "rdy=0");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule